// File: doc/BRIEF.md
# Dual-Ring Read-Return Merger

This block collects read-return traffic from two independent 65-bit ring buses, a local ring and a fast ring, and turns it into one stream of complete results for a single consumer. On each ring a transaction takes two consecutive beats. The first is a control beat that carries a header, and the second is a data beat that carries a 64-bit word. Every incoming beat is first captured in a stage-1 register. The header of a valid control beat is then decoded and paired with the data beat that follows it. The finished result is parked in a per-ring stage-2 register until it is delivered.

The output port presents at most one result per cycle. A result is the data word, thread id, ack, exception status and read/write flag, together with a source flag. When both rings finish a result in the same cycle, the fast ring is delivered first. The local result waits in its stage-2 register and is delivered on the next cycle. That cycle is always free, because neither ring can finish twice in a row. So both rings can stream transactions back to back at the same time without losing any.

Top module: `dual_ring_merge`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_vld` is low. A beat sampled while `rst` is high never produces a result.
- R2: Beat encoding on both rings. Bit 64 set means a control beat and bit 64 clear means a data beat. In a control beat, bit 63 is valid, bit 62 is ack, bit 59 is read (1) or write (0), bits 58:56 are the thread id and bits 49:48 are the exception status. In a data beat, bits 63:0 are the word. Each delivered result carries these header fields and the word unchanged.
- R3: A valid control beat is sampled at rising edge k and its data beat at edge k+1. If the other ring does not win the same cycle, the result is presented after edge k+2 for exactly one cycle.
- R4: A control beat with bit 63 clear produces no result, and the beat that follows it is not taken as data.
- R5: A data beat that was not preceded on the previous edge by a valid control beat on the same ring is dropped. A valid control beat followed by another control beat yields nothing for the first one.
- R6: `out_src` is 1 for a fast-ring result and 0 for a local-ring result. When both rings finish in the same cycle, the fast result is presented first and the local result is presented in the following cycle.
- R7: Back-to-back transactions on both rings at the same time are all delivered, in order per ring, with no loss and no overwrite of a result that has not been delivered.
- R8: Control-beat bits 61:60 (register class), bits 55:50 and bits 47:0 (address) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| loc_bus | input | 65 | Local ring beat |
| fst_bus | input | 65 | Fast ring beat |
| out_vld | output | 1 | One-cycle strobe per delivered result |
| out_src | output | 1 | Source of the result: 1 fast, 0 local |
| out_data | output | 64 | Result data word |
| out_tid | output | 3 | Result thread id |
| out_ack | output | 1 | Result ack bit |
| out_rd | output | 1 | Result read (1) / write (0) |
| out_exc | output | 2 | Result exception status |

## Verification
Several properties are checked on every cycle. These are the quiet output after reset, the fixed latency from a fast control/data pair to a fast result, and the absence of a fast result after an invalid control beat or an orphan data beat. They also include the rule that a held local result follows a fast one immediately, and that a stage-2 register is never reloaded while it still holds an undelivered result. Other behaviour can only be shown by the bench's scenarios, which compare every delivered result against a queue of expected items that includes the exact cycle of arrival. These scenarios cover the exact pairing of header fields with data words, the per-ring ordering under sustained dual-ring streams, the arrival cycle of held local results, and the fact that class and address bits have no effect.

// File: rtl/rmerge_pkg.sv
package rmerge_pkg;
    localparam int DATA_W  = 64;
    localparam int BUS_W   = DATA_W + 1;
    localparam int TID_W   = 3;
    localparam int EXC_W   = 2;
    // field positions of a control beat
    localparam int CTL_BIT = BUS_W - 1;
    localparam int VLD_BIT = 63;
    localparam int ACK_BIT = 62;
    localparam int RD_BIT  = 59;
    localparam int TID_LSB = 56;
    localparam int EXC_LSB = 48;

    typedef struct packed {
        logic             rd;
        logic [TID_W-1:0] tid;
        logic             ack;
        logic [EXC_W-1:0] exc;
    } hdr_t;

    typedef struct packed {
        hdr_t              hdr;
        logic [DATA_W-1:0] data;
    } result_t;

    function automatic hdr_t hdr_decode(input logic [BUS_W-1:0] beat);
        hdr_t h;
        h.rd  = beat[RD_BIT];
        h.tid = beat[TID_LSB +: TID_W];
        h.ack = beat[ACK_BIT];
        h.exc = beat[EXC_LSB +: EXC_W];
        return h;
    endfunction
endpackage

// File: rtl/rmerge_lane.sv
module rmerge_lane
    import rmerge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus,
    input  logic             grant,
    output logic             rdy,
    output logic             load,
    output result_t          res
);
    typedef struct packed {
        logic [BUS_W-1:0] beat;   // stage-1 capture
        logic             armed;  // valid control seen last cycle
        hdr_t             hdr;
        logic             rdy;    // stage-2 holds an undelivered result
        result_t          res;    // stage-2 result
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     is_ctl;
    logic     is_vld_ctl;

    always_comb begin
        st_d       = st_q;
        is_ctl     = st_q.beat[CTL_BIT];
        is_vld_ctl = is_ctl && st_q.beat[VLD_BIT];
        load       = st_q.armed && !is_ctl;

        st_d.beat  = bus;
        st_d.armed = is_vld_ctl;
        if (is_vld_ctl) begin
            st_d.hdr = hdr_decode(st_q.beat);
        end
        if (load) begin
            st_d.res.hdr  = st_q.hdr;
            st_d.res.data = st_q.beat[DATA_W-1:0];
        end
        st_d.rdy = load || (st_q.rdy && !grant);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy = st_q.rdy;
    assign res = st_q.res;
endmodule

// File: rtl/rmerge_arb.sv
module rmerge_arb
    import rmerge_pkg::*;
(
    input  logic    fst_rdy,
    input  logic    loc_rdy,
    input  result_t fst_res,
    input  result_t loc_res,
    output logic    fst_grant,
    output logic    loc_grant,
    output logic    out_vld,
    output logic    out_src,
    output result_t out_res
);
    always_comb begin
        fst_grant = fst_rdy;
        loc_grant = loc_rdy && !fst_rdy;
        out_vld   = fst_rdy || loc_rdy;
        out_src   = fst_rdy;
        out_res   = fst_rdy ? fst_res : loc_res;
    end
endmodule

// File: rtl/dual_ring_merge.sv
module dual_ring_merge
    import rmerge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  loc_bus,
    input  logic [BUS_W-1:0]  fst_bus,
    output logic              out_vld,
    output logic              out_src,
    output logic [DATA_W-1:0] out_data,
    output logic [TID_W-1:0]  out_tid,
    output logic              out_ack,
    output logic              out_rd,
    output logic [EXC_W-1:0]  out_exc
);
    logic    loc_rdy, fst_rdy, loc_load, fst_load, loc_grant, fst_grant;
    result_t loc_res, fst_res, out_res;

    rmerge_lane u_loc (
        .clk(clk), .rst(rst), .bus(loc_bus), .grant(loc_grant),
        .rdy(loc_rdy), .load(loc_load), .res(loc_res)
    );

    rmerge_lane u_fst (
        .clk(clk), .rst(rst), .bus(fst_bus), .grant(fst_grant),
        .rdy(fst_rdy), .load(fst_load), .res(fst_res)
    );

    rmerge_arb u_arb (
        .fst_rdy(fst_rdy), .loc_rdy(loc_rdy),
        .fst_res(fst_res), .loc_res(loc_res),
        .fst_grant(fst_grant), .loc_grant(loc_grant),
        .out_vld(out_vld), .out_src(out_src), .out_res(out_res)
    );

    assign out_data = out_res.data;
    assign out_tid  = out_res.hdr.tid;
    assign out_ack  = out_res.hdr.ack;
    assign out_rd   = out_res.hdr.rd;
    assign out_exc  = out_res.hdr.exc;
endmodule

// File: rtl/rmerge_chk.sv
module rmerge_chk (
    input logic        clk,
    input logic        rst,
    input logic [64:0] fst_bus,
    input logic        out_vld,
    input logic        out_src,
    input logic        loc_rdy,
    input logic        loc_load,
    input logic        loc_grant,
    input logic        fst_rdy,
    input logic        fst_load,
    input logic        fst_grant
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_vld); // R1

    AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (fst_bus[64] && fst_bus[63]) ##1 !fst_bus[64] |-> ##2 (out_vld && out_src)); // R3

    AST_INVALID_CTL: assert property (@(posedge clk) disable iff (rst)
        (fst_bus[64] && !fst_bus[63]) |-> ##3 !(out_vld && out_src)); // R4

    AST_ORPHAN_DATA: assert property (@(posedge clk) disable iff (rst)
        (!fst_bus[64] && !$past(fst_bus[64] && fst_bus[63])) |-> ##2 !(out_vld && out_src)); // R5

    AST_HOLD_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_src && loc_rdy) |=> (out_vld && !out_src)); // R6

    AST_NO_OVERWRITE_LOC: assert property (@(posedge clk) disable iff (rst)
        loc_load |-> (!loc_rdy || loc_grant)); // R7

    AST_NO_OVERWRITE_FST: assert property (@(posedge clk) disable iff (rst)
        fst_load |-> (!fst_rdy || fst_grant)); // R7
endmodule

bind dual_ring_merge rmerge_chk u_chk (
    .clk(clk), .rst(rst), .fst_bus(fst_bus),
    .out_vld(out_vld), .out_src(out_src),
    .loc_rdy(loc_rdy), .loc_load(loc_load), .loc_grant(loc_grant),
    .fst_rdy(fst_rdy), .fst_load(fst_load), .fst_grant(fst_grant)
);

// File: tb/dual_ring_merge_test.sv
module dual_ring_merge_test;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [64:0] loc_bus, fst_bus;
    logic        out_vld, out_src, out_ack, out_rd;
    logic [63:0] out_data;
    logic [2:0]  out_tid;
    logic [1:0]  out_exc;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        logic        src;
        logic [2:0]  tid;
        logic        ack;
        logic        rd;
        logic [1:0]  exc;
        logic [63:0] data;
        int          ecyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    dual_ring_merge uut (
        .clk(clk), .rst(rst), .loc_bus(loc_bus), .fst_bus(fst_bus),
        .out_vld(out_vld), .out_src(out_src), .out_data(out_data),
        .out_tid(out_tid), .out_ack(out_ack), .out_rd(out_rd), .out_exc(out_exc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // control beat: 64 ctl, 63 valid, 62 ack, 61:60 class, 59 rd, 58:56 tid, 55:50 spare, 49:48 exc, 47:0 addr
    function automatic logic [64:0] mk_ctl(input logic vld, ack, rd, input logic [2:0] tid,
                                           input logic [1:0] exc, cls, input logic [47:0] addr);
        logic [64:0] w;
        w = '0;
        w[64] = 1'b1; w[63] = vld; w[62] = ack; w[61:60] = cls; w[59] = rd;
        w[58:56] = tid; w[55:50] = 6'h2a & {6{cls[0]}}; w[49:48] = exc; w[47:0] = addr;
        return w;
    endfunction

    function automatic logic [64:0] mk_dat(input logic [63:0] d);
        return {1'b0, d};
    endfunction

    task automatic push(input logic src, input logic [64:0] c, input logic [63:0] d,
                        input int ecyc, input string tag);
        exp_t e;
        e.src = src; e.tid = c[58:56]; e.ack = c[62]; e.rd = c[59]; e.exc = c[49:48];
        e.data = d; e.ecyc = ecyc; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drive(input logic [64:0] l, input logic [64:0] f);
        @(negedge clk);
        loc_bus = l;
        fst_bus = f;
    endtask

    // one two-beat slot on either or both rings
    task automatic pair(input logic use_l, input logic use_f,
                        input logic [64:0] lc, input logic [63:0] ld,
                        input logic [64:0] fc, input logic [63:0] fd, input string tag);
        int ce;
        drive(use_l ? lc : 65'd0, use_f ? fc : 65'd0);
        ce = cyc + 1;
        drive(use_l ? mk_dat(ld) : 65'd0, use_f ? mk_dat(fd) : 65'd0);
        if (use_f) push(1'b1, fc, fd, ce + 2, tag);
        if (use_l) push(1'b0, lc, ld, ce + 2 + (use_f ? 1 : 0), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, '0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_vld) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 R5: unexpected result src=%0b tid=%0d data=%h, expected none",
                             out_src, out_tid, out_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (out_src !== e.src || out_tid !== e.tid || out_ack !== e.ack ||
                        out_rd !== e.rd || out_exc !== e.exc || out_data !== e.data || cyc != e.ecyc) begin
                        errors++;
                        $display("FAIL %s: got src=%0b tid=%0d ack=%0b rd=%0b exc=%0d data=%h cyc=%0d, expected src=%0b tid=%0d ack=%0b rd=%0b exc=%0d data=%h cyc=%0d",
                                 e.tag, out_src, out_tid, out_ack, out_rd, out_exc, out_data, cyc,
                                 e.src, e.tid, e.ack, e.rd, e.exc, e.data, e.ecyc);
                    end
                end
            end else if (q.size() > 0 && cyc >= q[0].ecyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                errors++;
                $display("FAIL %s: no result at cyc=%0d, expected src=%0b data=%h at cyc=%0d",
                         e.tag, cyc, e.src, e.data, e.ecyc);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        loc_bus = '0;
        fst_bus = '0;
        // R1: a control beat during reset, data after release, must give nothing
        drive(mk_ctl(1, 1, 1, 3'd5, 2'd1, 2'd0, 48'h1), mk_ctl(1, 0, 1, 3'd2, 2'd0, 2'd1, 48'h2));
        drive(mk_ctl(1, 1, 1, 3'd5, 2'd1, 2'd0, 48'h1), mk_ctl(1, 0, 1, 3'd2, 2'd0, 2'd1, 48'h2));
        checks++;
        if (out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_vld=%b during reset, expected 0", out_vld);
        end
        @(negedge clk);
        rst = 1'b0;
        loc_bus = mk_dat(64'hdead);
        fst_bus = mk_dat(64'hbeef);
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_vld=%b after reset, expected 0", out_vld);
        end
        idle(3);

        // R2 R3: single transactions on each ring
        pair(1, 0, mk_ctl(1, 1, 1, 3'd3, 2'd2, 2'd0, 48'h123), 64'h0123_4567_89ab_cdef, '0, '0, "R2");
        idle(3);
        pair(0, 1, '0, '0, mk_ctl(1, 0, 0, 3'd6, 2'd1, 2'd3, 48'hfff), 64'hfeed_face_0000_1111, "R3");
        idle(3);

        // R4: invalid control, then a data-looking beat, on both rings
        drive(mk_ctl(0, 1, 1, 3'd1, 2'd3, 2'd0, 48'h0), mk_ctl(0, 1, 1, 3'd1, 2'd3, 2'd0, 48'h0));
        drive(mk_dat(64'h4444), mk_dat(64'h5555));
        idle(4);

        // R5: orphan data beats, and a control followed by a control
        drive(mk_dat(64'h6666), mk_dat(64'h7777));
        drive(mk_dat(64'h8888), mk_dat(64'h9999));
        idle(2);
        drive('0, mk_ctl(1, 1, 0, 3'd7, 2'd0, 2'd0, 48'h10));
        pair(0, 1, '0, '0, mk_ctl(1, 0, 1, 3'd4, 2'd2, 2'd2, 48'h20), 64'h5a5a_5a5a_5a5a_5a5a, "R5");
        idle(4);

        // R6: simultaneous completion, fast first then local
        pair(1, 1, mk_ctl(1, 1, 0, 3'd1, 2'd1, 2'd1, 48'h30), 64'h1111_aaaa_1111_aaaa,
                   mk_ctl(1, 0, 1, 3'd2, 2'd2, 2'd0, 48'h40), 64'h2222_bbbb_2222_bbbb, "R6");
        idle(4);

        // R7: sustained back-to-back on both rings
        for (int i = 0; i < 8; i++) begin
            pair(1, 1, mk_ctl(1, i[0], i[1], i[2:0], i[1:0], 2'd0, 48'(i)), {32'hc0de_0000, 32'(i)},
                       mk_ctl(1, !i[0], !i[1], 3'(7 - i), 2'(3 - i), 2'd3, 48'(i * 3)), {32'hface_0000, 32'(i)}, "R7");
        end
        // local alone back-to-back
        for (int i = 0; i < 4; i++) begin
            pair(1, 0, mk_ctl(1, 1, 1, 3'(i), 2'd0, 2'd2, 48'h55), {48'h0, 16'(i)}, '0, '0, "R7");
        end
        idle(4);

        // R8: class and address bits vary, outputs depend only on header and data
        for (int c = 0; c < 4; c++) begin
            pair(1, 0, mk_ctl(1, 1, 0, 3'd5, 2'd3, 2'(c), {12'(c), 36'hfedcba987}), 64'h0f0f_0f0f_0f0f_0f0f,
                       '0, '0, "R8");
            pair(0, 1, '0, '0, mk_ctl(1, 0, 1, 3'd2, 2'd1, 2'(3 - c), 48'(c * 7)), 64'hf0f0_f0f0_f0f0_f0f0, "R8");
        end
        idle(6);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R7: %0d results never delivered, expected 0", q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule